// File: doc/BRIEF.md
# Hysteretic RTS/CTS flow controller

This block runs the hardware handshake lines of a UART whose receive and transmit FIFOs hold 64 characters. On the receive side it watches the receive FIFO fill count. Once the fill passes a programmable upper mark, it tells the far end to stop sending. It does not let the far end resume until the fill has drained under a separate, lower mark. Two independent marks give hysteresis, so the RTS line does not chatter around a single threshold. When automatic RTS is turned off, the line simply follows a software-controlled bit.

On the transmit side the block synchronizes the incoming CTS pin and produces a permit signal. The transmitter samples this permit before it starts each new character, so a character already being shifted out is always finished. Both handshake pins are active low. A one-cycle strobe marks every change of the RTS state and of the synchronized CTS state, for the interrupt logic.

The two marks are 4-bit fields. Each field is scaled by four, so a mark can sit anywhere from 0 to 60 characters. The fields are held inside the block and loaded from a write strobe.

Top module: `hw_flow_ctrl`

## Requirements
- R1: After reset, rts_no_o is 1 (RTS not asserted) and both strobes are 0. The synchronized CTS state is "not asserted", so tx_permit_o is 0 while auto_cts_en_i is 1. The stop field resets to 14 (56 characters) and the go field resets to 8 (32 characters).
- R2: While cfg_we_i is 1 at a clock edge, the block loads halt_lvl_i and resume_lvl_i. From the next cycle the marks in effect are field×4 characters.
- R3: With auto_rts_en_i = 1 and RTS asserted, a rx_level_i strictly above the stop mark at a clock edge makes rts_no_o go to 1 in the following cycle. A level equal to the mark keeps RTS asserted.
- R4: With auto_rts_en_i = 1 and RTS not asserted, a rx_level_i strictly below the go mark makes rts_no_o go to 0 in the following cycle. Levels from the go mark up to the stop mark leave the state unchanged.
- R5: A go field of 0 never reasserts RTS, even at a fill of 0. A stop field of 15 places the stop mark at 60: a fill of 60 keeps RTS asserted and a fill of 61 releases it.
- R6: With auto_rts_en_i = 0, rts_no_o equals the inverse of manual_rts_i one cycle later, whatever rx_level_i is.
- R7: cts_ni passes through a two-stage synchronizer. With auto_cts_en_i = 1, tx_permit_o equals the inverse of cts_ni from two clock edges earlier. With auto_cts_en_i = 0, tx_permit_o is 1.
- R8: rts_chg_o is 1 for exactly the cycle in which rts_no_o first shows a new value, and 0 otherwise.
- R9: cts_chg_o is 1 for exactly the cycle in which the synchronized CTS state first shows a new value, whether or not auto_cts_en_i is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | 7 | Receive FIFO fill count, 0..64 |
| cts_ni | input | 1 | CTS pin from the far end, active low, asynchronous |
| cfg_we_i | input | 1 | Load strobe for the two threshold fields |
| halt_lvl_i | input | 4 | Stop field, mark = value×4 |
| resume_lvl_i | input | 4 | Go field, mark = value×4 |
| auto_rts_en_i | input | 1 | Enable automatic RTS from the FIFO fill |
| auto_cts_en_i | input | 1 | Enable gating of the transmitter by CTS |
| manual_rts_i | input | 1 | RTS request used when automatic RTS is off, 1 = assert |
| rts_no_o | output | 1 | RTS pin to the far end, active low |
| tx_permit_o | output | 1 | 1 = the transmitter may start the next character |
| rts_chg_o | output | 1 | One-cycle strobe on an RTS state change |
| cts_chg_o | output | 1 | One-cycle strobe on a synchronized CTS change |

## Verification
The bench builds the block with its defaults: a 64-entry FIFO, 4-bit fields scaled by four and a two-stage synchronizer. With these values the count port reaches 64, above the highest mark of 60. This puts the fill at the edge of each mark within reach: 56/57 and 31/32 at the reset fields, 60/61 at the top field, and the dead state of a zero go field. The synchronizer depth fixes CTS latency at two edges, which the bench counts exactly.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  localparam int unsigned THR_W = 4;
  localparam logic [THR_W-1:0] HALT_RST   = 4'hE;
  localparam logic [THR_W-1:0] RESUME_RST = 4'h8;

  typedef struct packed {
    logic [THR_W-1:0] halt;
    logic [THR_W-1:0] resume;
  } thr_t;
endpackage

// File: rtl/hfc_sync.sv
module hfc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/hfc_toggle_det.sv
module hfc_toggle_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic chg_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;

  assign chg_o = sig_i ^ prev_q;
endmodule

// File: rtl/hfc_rts_ctrl.sv
module hfc_rts_ctrl #(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] halt_lvl_i,
  input  logic [LVL_W-1:0] resume_lvl_i,
  input  logic             auto_i,
  input  logic             manual_i,
  output logic             rts_on_o
);
  logic rts_q, rts_d;

  always_comb begin
    rts_d = rts_q;
    if (!auto_i)                             rts_d = manual_i;
    else if (rts_q && level_i > halt_lvl_i)    rts_d = 1'b0;
    else if (!rts_q && level_i < resume_lvl_i) rts_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rts_q <= 1'b0;
    else         rts_q <= rts_d;

  assign rts_on_o = rts_q;
endmodule

// File: rtl/hw_flow_ctrl.sv
module hw_flow_ctrl
  import hfc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 64,
  parameter int unsigned THR_SCALE   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned SCALE_SH   = $clog2(THR_SCALE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             cts_ni,
  input  logic             cfg_we_i,
  input  logic [THR_W-1:0] halt_lvl_i,
  input  logic [THR_W-1:0] resume_lvl_i,
  input  logic             auto_rts_en_i,
  input  logic             auto_cts_en_i,
  input  logic             manual_rts_i,
  output logic             rts_no_o,
  output logic             tx_permit_o,
  output logic             rts_chg_o,
  output logic             cts_chg_o
);
  thr_t             thr_q;
  logic [LVL_W-1:0] halt_lvl, resume_lvl;
  logic             rts_on, cts_pin_s, cts_on;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       thr_q <= '{halt: HALT_RST, resume: RESUME_RST};
    else if (cfg_we_i) thr_q <= '{halt: halt_lvl_i, resume: resume_lvl_i};

  assign halt_lvl   = LVL_W'(thr_q.halt)   << SCALE_SH;
  assign resume_lvl = LVL_W'(thr_q.resume) << SCALE_SH;

  hfc_rts_ctrl #(.LVL_W(LVL_W)) u_rts (
    .clk_i, .rst_ni,
    .level_i     (rx_level_i),
    .halt_lvl_i  (halt_lvl),
    .resume_lvl_i(resume_lvl),
    .auto_i      (auto_rts_en_i),
    .manual_i    (manual_rts_i),
    .rts_on_o    (rts_on)
  );

  hfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk_i, .rst_ni, .d_i(cts_ni), .q_o(cts_pin_s)
  );
  assign cts_on = ~cts_pin_s;

  hfc_toggle_det #(.RST_VAL(1'b0)) u_rts_det (
    .clk_i, .rst_ni, .sig_i(rts_on), .chg_o(rts_chg_o)
  );
  hfc_toggle_det #(.RST_VAL(1'b0)) u_cts_det (
    .clk_i, .rst_ni, .sig_i(cts_on), .chg_o(cts_chg_o)
  );

  assign rts_no_o    = ~rts_on;
  assign tx_permit_o = ~auto_cts_en_i | cts_on;
endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
  parameter int unsigned LVL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] halt_lvl,
  input logic [LVL_W-1:0] resume_lvl,
  input logic             auto_rts_en_i,
  input logic             auto_cts_en_i,
  input logic             manual_rts_i,
  input logic             rts_no_o,
  input logic             tx_permit_o,
  input logic             rts_chg_o
);
  assert_halt_above_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rts_en_i && !rts_no_o && rx_level_i > halt_lvl |=> rts_no_o);

  assert_hold_at_mark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rts_en_i && !rts_no_o && rx_level_i <= halt_lvl |=> !rts_no_o);

  assert_resume_below_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rts_en_i && rts_no_o && rx_level_i < resume_lvl |=> !rts_no_o);

  assert_manual_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> rts_no_o == !$past(manual_rts_i));

  assert_permit_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_cts_en_i |-> tx_permit_o);

  assert_rts_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_chg_o |-> rts_no_o != $past(rts_no_o));
endmodule

bind hw_flow_ctrl hfc_checker #(.LVL_W(LVL_W)) u_hfc_checker (
  .clk_i, .rst_ni, .rx_level_i, .halt_lvl, .resume_lvl,
  .auto_rts_en_i, .auto_cts_en_i, .manual_rts_i,
  .rts_no_o, .tx_permit_o, .rts_chg_o
);

// File: tb/hw_flow_ctrl_test.sv
module hw_flow_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] rx_level_i = '0;
  logic       cts_ni = 1'b1;
  logic       cfg_we_i = 1'b0;
  logic [3:0] halt_lvl_i = '0;
  logic [3:0] resume_lvl_i = '0;
  logic       auto_rts_en_i = 1'b0;
  logic       auto_cts_en_i = 1'b1;
  logic       manual_rts_i = 1'b0;
  logic       rts_no_o, tx_permit_o, rts_chg_o, cts_chg_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  hw_flow_ctrl uut (
    .clk_i, .rst_ni, .rx_level_i, .cts_ni, .cfg_we_i, .halt_lvl_i,
    .resume_lvl_i, .auto_rts_en_i, .auto_cts_en_i, .manual_rts_i,
    .rts_no_o, .tx_permit_o, .rts_chg_o, .cts_chg_o
  );

  // {auto, manual, level[6:0], expected rts_no}, default marks 56 / 32
  localparam logic [9:0] VEC [0:9] = '{
    {1'b1, 1'b0, 7'd0,  1'b0},  // R4 drained below go mark
    {1'b1, 1'b0, 7'd56, 1'b0},  // R3 equal to stop mark
    {1'b1, 1'b0, 7'd57, 1'b1},  // R1 R3 above 56
    {1'b1, 1'b0, 7'd40, 1'b1},  // R4 band holds
    {1'b1, 1'b0, 7'd32, 1'b1},  // R4 equal to go mark
    {1'b1, 1'b0, 7'd31, 1'b0},  // R1 R4 below 32
    {1'b1, 1'b0, 7'd50, 1'b0},  // R3 band holds
    {1'b0, 1'b0, 7'd50, 1'b1},  // R6 manual off
    {1'b0, 1'b1, 7'd64, 1'b0},  // R6 manual on, full fifo ignored
    {1'b1, 1'b1, 7'd64, 1'b1}   // R3 auto back, above mark
  };

  task automatic tick();
    @(posedge clk_i);
    #5;
  endtask

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic load_thr(logic [3:0] h, logic [3:0] r);
    cfg_we_i = 1'b1; halt_lvl_i = h; resume_lvl_i = r;
    tick();
    cfg_we_i = 1'b0;
  endtask

  initial begin
    logic prev_exp;
    repeat (3) @(posedge clk_i);
    #5;
    chk("R1 rts_no", rts_no_o, 1'b1);
    chk("R1 permit", tx_permit_o, 1'b0);
    chk("R1 rts_chg", rts_chg_o, 1'b0);
    chk("R1 cts_chg", cts_chg_o, 1'b0);
    rst_ni = 1'b1;
    tick();

    prev_exp = 1'b1;
    for (int i = 0; i < 10; i++) begin
      auto_rts_en_i = VEC[i][9];
      manual_rts_i  = VEC[i][8];
      rx_level_i    = VEC[i][7:1];
      tick();
      chk("R3/R4/R6 vector rts_no", rts_no_o, VEC[i][0]);
      chk("R8 vector rts_chg", rts_chg_o, VEC[i][0] != prev_exp);
      prev_exp = VEC[i][0];
    end
    tick();
    chk("R8 strobe one cycle", rts_chg_o, 1'b0);

    // R2: marks 8 / 4
    load_thr(4'd2, 4'd1);
    rx_level_i = 7'd4; tick();
    chk("R2 go mark 4 not below", rts_no_o, 1'b1);
    rx_level_i = 7'd3; tick();
    chk("R2 below 4", rts_no_o, 1'b0);
    rx_level_i = 7'd8; tick();
    chk("R2 equal 8 holds", rts_no_o, 1'b0);
    rx_level_i = 7'd9; tick();
    chk("R2 above 8", rts_no_o, 1'b1);

    // R5: stop 60, go 0
    load_thr(4'd15, 4'd0);
    rx_level_i = 7'd0; tick(); tick();
    chk("R5 zero go mark never resumes", rts_no_o, 1'b1);
    auto_rts_en_i = 1'b0; manual_rts_i = 1'b1; tick();
    chk("R6 manual assert", rts_no_o, 1'b0);
    auto_rts_en_i = 1'b1; rx_level_i = 7'd60; tick();
    chk("R5 at 60 holds", rts_no_o, 1'b0);
    rx_level_i = 7'd61; tick();
    chk("R5 above 60", rts_no_o, 1'b1);

    // R7 / R9
    cts_ni = 1'b0; tick();
    chk("R7 first stage only", tx_permit_o, 1'b0);
    chk("R9 no strobe yet", cts_chg_o, 1'b0);
    tick();
    chk("R7 permit after two edges", tx_permit_o, 1'b1);
    chk("R9 cts strobe", cts_chg_o, 1'b1);
    tick();
    chk("R9 strobe one cycle", cts_chg_o, 1'b0);
    chk("R7 permit holds", tx_permit_o, 1'b1);
    cts_ni = 1'b1; tick(); tick();
    chk("R7 permit withdrawn", tx_permit_o, 1'b0);
    chk("R9 cts strobe on release", cts_chg_o, 1'b1);
    auto_cts_en_i = 1'b0; tick();
    chk("R7 auto cts off", tx_permit_o, 1'b1);
    cts_ni = 1'b0; tick(); tick();
    chk("R9 strobe without auto cts", cts_chg_o, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule